// File: doc/BRIEF.md
# Sync-Checking Packet Serial Receiver

This block listens on one asynchronous serial line and extracts protected data bytes from a fixed four-frame packet. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. A packet is built from four such frames: the preamble value 0x99, then the preamble value 0x88, then a payload byte, then the bitwise complement of that payload byte.

The receiver checks every frame. It confirms the start bit at the half-bit point and checks the stop bit at its centre. It also compares both preamble bytes against their fixed values. If any of these checks fails, it drops the partial packet and starts looking for a new packet from its first frame. When all four frames arrive, the payload goes to the output with a one-cycle valid strobe, but only if the fourth byte is the exact complement of the third. If the fourth byte is not the exact complement, the receiver raises a one-cycle error strobe instead.

The bit period is a parameter given in clock cycles. With the default of 1000, a 1 MHz clock gives 1 kbit/s. Each frame realigns to its own start edge, so the idle gap between frames can be any length.

Top module: `pkt_sync_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `valid_o` and `err_o` are 0 and `data_o` is 0x00.
- R2: A start bit counts only if the synchronized line is still low half a bit period after its falling edge. A low pulse shorter than that, between frames, cancels the packet in progress, so no valid strobe and no error strobe follow for that packet.
- R3: Data bits are sampled at the centre of each bit period and assembled least significant bit first. A correct packet 0x99, 0x88, D, ~D puts D on `data_o` with `valid_o` high for exactly one cycle.
- R4: If the first frame's byte is not 0x99, the packet is dropped, and no strobe follows.
- R5: If the second frame's byte is not 0x88, the packet is dropped, and no strobe follows.
- R6: If any frame's stop bit is sampled low, the packet is dropped, and no strobe follows.
- R7: If the fourth byte is not the exact bitwise complement of the third, `err_o` pulses for one cycle, `valid_o` stays low and `data_o` keeps its previous value. This includes fourth bytes whose AND with the third byte is 0x00.
- R8: After a frame ends, whether it completes or fails, the receiver waits for the line to be high before it looks for another start bit. After a long low break, a correct packet sent once the line returns high is received.
- R9: `valid_o` and `err_o` are single-cycle strobes and are never high together. `data_o` changes only in a cycle where `valid_o` is high.
- R10: Idle gaps of any length, including zero, between the frames of a packet do not affect reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receiver clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | 8 | Last payload that passed the complement check |
| valid_o | output | 1 | One-cycle strobe: a new payload is on `data_o` |
| err_o | output | 1 | One-cycle strobe: a complete packet failed the complement check |

## Verification
The checker tests some properties on every clock cycle:
- The two strobes are each one cycle long and never high together.
- `data_o` changes only together with `valid_o`.
- A valid strobe always directly follows a completed frame.
- The frame engine never reports a completed byte and a framing failure in the same cycle.

Some behaviours show only in the bench's packet scenarios:
- The preamble checks and the stop-bit abort.
- Rejection of a short start pulse.
- Recovery after a long break.
- Least-significant-bit-first assembly.
- The difference between an exact complement and a fourth byte that merely ANDs to zero.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  localparam int          BYTE_W  = 8;
  localparam logic [7:0]  PRE_ONE = 8'h99;
  localparam logic [7:0]  PRE_TWO = 8'h88;

  typedef enum logic [2:0] {
    F_WAIT_HIGH,
    F_HUNT,
    F_START,
    F_DATA,
    F_STOP
  } frame_st_e;

  typedef enum logic [1:0] {
    P_PRE_ONE,
    P_PRE_TWO,
    P_PAYLOAD,
    P_CHECK
  } pkt_st_e;

endpackage

// File: rtl/pkt_rx_sync.sv
module pkt_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= {STAGES{RST_VAL}};
    end else begin
      ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/pkt_rx_frame.sv
module pkt_rx_frame
  import pkt_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1000,
  parameter int DATA_BITS    = BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_i,
  output logic                 done_o,
  output logic                 ferr_o,
  output logic [DATA_BITS-1:0] byte_o
);

  localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BIT_W = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLKS_PER_BIT / 2 - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_BITS - 1);

  frame_st_e            st_q, st_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 done_q, done_d;
  logic                 ferr_q, ferr_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    ferr_d = 1'b0;
    unique case (st_q)
      F_WAIT_HIGH: begin
        if (line_i) st_d = F_HUNT;
      end
      F_HUNT: begin
        if (!line_i) begin
          st_d  = F_START;
          cnt_d = '0;
        end
      end
      F_START: begin
        if (cnt_q == HALF_LAST) begin
          cnt_d = '0;
          bit_d = '0;
          if (!line_i) begin
            st_d = F_DATA;
          end else begin
            st_d   = F_WAIT_HIGH;
            ferr_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      F_DATA: begin
        if (cnt_q == FULL_LAST) begin
          cnt_d = '0;
          sh_d  = {line_i, sh_q[DATA_BITS-1:1]};
          if (bit_q == BIT_LAST) begin
            st_d = F_STOP;
          end else begin
            bit_d = bit_q + BIT_W'(1);
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      F_STOP: begin
        if (cnt_q == FULL_LAST) begin
          cnt_d = '0;
          st_d  = F_WAIT_HIGH;
          if (line_i) done_d = 1'b1;
          else        ferr_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = F_WAIT_HIGH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_WAIT_HIGH;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      ferr_q <= ferr_d;
    end
  end

  assign done_o = done_q;
  assign ferr_o = ferr_q;
  assign byte_o = sh_q;

endmodule

// File: rtl/pkt_rx_seq.sv
module pkt_rx_seq
  import pkt_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              ferr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o
);

  pkt_st_e           stg_q, stg_d;
  logic [BYTE_W-1:0] pay_q, pay_d;
  logic [BYTE_W-1:0] out_q, out_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;
  logic              pay_en;
  logic              out_en;

  always_comb begin
    stg_d  = stg_q;
    pay_en = 1'b0;
    out_en = 1'b0;
    vld_d  = 1'b0;
    err_d  = 1'b0;
    if (ferr_i) begin
      stg_d = P_PRE_ONE;
    end else if (done_i) begin
      unique case (stg_q)
        P_PRE_ONE: if (byte_i == PRE_ONE) stg_d = P_PRE_TWO;
        P_PRE_TWO: stg_d = (byte_i == PRE_TWO) ? P_PAYLOAD : P_PRE_ONE;
        P_PAYLOAD: begin
          pay_en = 1'b1;
          stg_d  = P_CHECK;
        end
        P_CHECK: begin
          stg_d = P_PRE_ONE;
          if (byte_i == ~pay_q) begin
            out_en = 1'b1;
            vld_d  = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
        default: stg_d = P_PRE_ONE;
      endcase
    end
  end

  assign pay_d = pay_en ? byte_i : pay_q;
  assign out_d = out_en ? pay_q  : out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= P_PRE_ONE;
      pay_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      stg_q <= stg_d;
      pay_q <= pay_d;
      out_q <= out_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign data_o  = out_q;
  assign valid_o = vld_q;
  assign err_o   = err_q;

endmodule

// File: rtl/pkt_sync_rx.sv
module pkt_sync_rx
  import pkt_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o
);

  logic              line_s;
  logic              byte_done;
  logic              frame_err;
  logic [BYTE_W-1:0] byte_val;

  pkt_rx_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (line_s)
  );

  pkt_rx_frame #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .DATA_BITS    (BYTE_W)
  ) frame_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_s),
    .done_o (byte_done),
    .ferr_o (frame_err),
    .byte_o (byte_val)
  );

  pkt_rx_seq seq_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (byte_done),
    .ferr_i  (frame_err),
    .byte_i  (byte_val),
    .data_o  (data_o),
    .valid_o (valid_o),
    .err_o   (err_o)
  );

endmodule

// File: rtl/pkt_sync_rx_chk.sv
module pkt_sync_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] data_o,
  input logic       valid_o,
  input logic       err_o,
  input logic       byte_done,
  input logic       frame_err
);

  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  assert_valid_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_err_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_data_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  assert_valid_after_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(byte_done));

  assert_frame_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_done && frame_err));

endmodule

bind pkt_sync_rx pkt_sync_rx_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_o    (data_o),
  .valid_o   (valid_o),
  .err_o     (err_o),
  .byte_done (byte_done),
  .frame_err (frame_err)
);

// File: tb/pkt_sync_rx_tb_top.sv
module pkt_sync_rx_tb_top;

  localparam int CPB = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx;
  logic [7:0] data;
  logic       vld;
  logic       err;

  int n_cmp = 0;
  int n_bad = 0;
  int vcnt  = 0;
  int ecnt  = 0;
  logic [7:0] exp_hold = 8'h00;

  always #2 clk = ~clk;

  pkt_sync_rx #(.CLKS_PER_BIT(CPB), .SYNC_STAGES(2)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .rx_i    (rx),
    .data_o  (data),
    .valid_o (vld),
    .err_o   (err)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (vld === 1'b1) vcnt++;
      if (err === 1'b1) ecnt++;
    end
  end

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_line(logic v, int cycles);
    rx <= v;
    repeat (cycles) @(posedge clk);
  endtask

  task automatic send_frame(logic [7:0] b, bit stop_ok);
    hold_line(1'b0, CPB);
    for (int i = 0; i < 8; i++) hold_line(b[i], CPB);
    hold_line(stop_ok, CPB);
    if (!stop_ok) hold_line(1'b1, CPB);
  endtask

  // bad_stop: index of frame whose stop bit is driven low, -1 for none
  task automatic run_pkt(string tag, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                         logic [7:0] b3, int bad_stop, int gap, bit ev, bit ee);
    int v0;
    int e0;
    logic [7:0] fr [4];
    v0 = vcnt;
    e0 = ecnt;
    fr[0] = b0; fr[1] = b1; fr[2] = b2; fr[3] = b3;
    for (int k = 0; k < 4; k++) begin
      send_frame(fr[k], bad_stop != k);
      if (gap > 0) hold_line(1'b1, gap * CPB);
    end
    hold_line(1'b1, 3 * CPB);
    chk({tag, " valid count"}, vcnt - v0, int'(ev));
    chk({tag, " error count"}, ecnt - e0, int'(ee));
    if (ev) exp_hold = b2;
    chk({tag, " data_o"}, int'(data), int'(exp_hold));
  endtask

  function automatic logic [7:0] pick_payload();
    logic [7:0] d;
    do d = 8'($urandom_range(0, 255)); while (d == 8'h99 || d == 8'h66);
    return d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    int v0;
    int e0;
    void'($urandom(32'd20250611));
    rst_n = 1'b0;
    rx    = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk("R1 reset valid", int'(vld), 0);
    chk("R1 reset err", int'(err), 0);
    chk("R1 reset data", int'(data), 0);
    @(posedge clk);
    rst_n <= 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 after release valid", int'(vld), 0);
    chk("R1 after release data", int'(data), 0);
    @(posedge clk);

    run_pkt("R3 payload A5", 8'h99, 8'h88, 8'hA5, 8'h5A, -1, 1, 1'b1, 1'b0);
    run_pkt("R3 payload 01 lsb first", 8'h99, 8'h88, 8'h01, 8'hFE, -1, 2, 1'b1, 1'b0);
    run_pkt("R10 zero gap payload 00", 8'h99, 8'h88, 8'h00, 8'hFF, -1, 0, 1'b1, 1'b0);
    run_pkt("R10 long gap payload FF", 8'h99, 8'h88, 8'hFF, 8'h00, -1, 7, 1'b1, 1'b0);
    run_pkt("R4 wrong first byte", 8'h98, 8'h88, 8'h3C, 8'hC3, -1, 1, 1'b0, 1'b0);
    run_pkt("R5 wrong second byte", 8'h99, 8'h89, 8'h3C, 8'hC3, -1, 1, 1'b0, 1'b0);
    run_pkt("R6 low stop on payload", 8'h99, 8'h88, 8'h3C, 8'hC3, 2, 1, 1'b0, 1'b0);
    run_pkt("R6 low stop on check", 8'h99, 8'h88, 8'h3C, 8'hC3, 3, 1, 1'b0, 1'b0);
    run_pkt("R7 AND zero not complement", 8'h99, 8'h88, 8'h0F, 8'h00, -1, 1, 1'b0, 1'b1);
    run_pkt("R7 one bit off", 8'h99, 8'h88, 8'h12, 8'hED ^ 8'h40, -1, 0, 1'b0, 1'b1);

    // R2: short low pulse between second and third frame
    v0 = vcnt;
    e0 = ecnt;
    send_frame(8'h99, 1'b1);
    send_frame(8'h88, 1'b1);
    hold_line(1'b1, CPB);
    hold_line(1'b0, CPB / 4);
    hold_line(1'b1, CPB);
    send_frame(8'h44, 1'b1);
    send_frame(8'hBB, 1'b1);
    hold_line(1'b1, 3 * CPB);
    chk("R2 short start pulse valid", vcnt - v0, 0);
    chk("R2 short start pulse err", ecnt - e0, 0);
    chk("R2 short start pulse data", int'(data), int'(exp_hold));

    // R8: long break then a clean packet
    v0 = vcnt;
    e0 = ecnt;
    hold_line(1'b0, 30 * CPB);
    hold_line(1'b1, 2 * CPB);
    chk("R8 break no valid", vcnt - v0, 0);
    chk("R8 break no err", ecnt - e0, 0);
    run_pkt("R8 packet after break", 8'h99, 8'h88, 8'h6D, 8'h92, -1, 1, 1'b1, 1'b0);

    for (int n = 0; n < 24; n++) begin
      int kind;
      int gap;
      logic [7:0] d;
      logic [7:0] w;
      kind = $urandom_range(0, 4);
      gap  = $urandom_range(0, 3);
      d    = pick_payload();
      case (kind)
        0: run_pkt("R3 random good", 8'h99, 8'h88, d, ~d, -1, gap, 1'b1, 1'b0);
        1: begin
          do w = 8'($urandom_range(0, 255)); while (w == 8'h99);
          run_pkt("R4 random first", w, 8'h88, d, ~d, -1, gap, 1'b0, 1'b0);
        end
        2: begin
          do w = 8'($urandom_range(0, 255)); while (w == 8'h88);
          run_pkt("R5 random second", 8'h99, w, d, ~d, -1, gap, 1'b0, 1'b0);
        end
        3: run_pkt("R6 random stop", 8'h99, 8'h88, d, ~d, $urandom_range(0, 3), gap,
                   1'b0, 1'b0);
        default: begin
          w = 8'($urandom_range(1, 255));
          run_pkt("R7 random bad complement", 8'h99, 8'h88, d, ~d ^ w, -1, gap,
                  1'b0, 1'b1);
        end
      endcase
    end

    report();
    $finish;
  end

endmodule